// File: doc/BRIEF.md
# Hysteretic Output-Port Congestion Marker

This block sits beside the hot-packet queues of a switch and decides, for each output port, whether that port is congested. Each hot queue has an occupancy counter. Per-queue enqueue and dequeue strobes drive the counter, but only while the queue is allocated. The surrounding logic allocates a hot queue only after the cold queue has passed its own allocation level. That decision is made outside this block and arrives here as a per-queue allocated flag.

A port becomes congested when any hot queue that feeds it reaches the programmable high threshold. The flags are released together, and only once every hot queue in the whole switch sits below a separate, lower threshold. Entry is decided per port, but exit depends on the whole switch. This hysteresis stops ports from toggling while a congestion tree drains.

Packet headers leaving the switch pass through a single register stage. In that stage the forward congestion bit is set on any header whose output port is flagged. All other header bits are copied unchanged. A mark already set upstream is never cleared.

Top module: `cm_marker`

## Requirements
- R1: An allocated queue's occupancy rises by one on an enqueue strobe and falls by one on a dequeue strobe. When both strobes are high in the same cycle, the occupancy does not change. The new value appears one cycle after the strobe.
- R2: While a queue's allocated flag is low, its occupancy is forced to zero on the next cycle and both strobes are ignored.
- R3: An occupancy at its maximum value (all ones) stays there on an enqueue alone. An occupancy at zero stays there on a dequeue alone.
- R4: A port's congested flag rises one cycle after any allocated queue feeding it holds an occupancy at or above the high threshold. Queue q feeds port q / queues-per-port. Flags of other ports do not change as a result.
- R5: Once raised, a port's flag stays set as long as at least one queue anywhere in the switch holds an occupancy at or above the low threshold.
- R6: All congested flags clear together one cycle after every queue's occupancy is below the low threshold. A deallocated queue counts as empty.
- R7: A header presented with its valid strobe leaves one cycle later, with the same output port. Its forward congestion bit (bit 13 with default parameters) is set if its port is flagged in the cycle the header is presented.
- R8: A header that arrives with the forward congestion bit already set leaves with it set, whatever the state of its port.
- R9: Every header bit other than the forward congestion bit leaves unchanged.
- R10: A threshold write is accepted only when the new low value is strictly below the new high value. Otherwise both thresholds keep their previous values. After reset the thresholds are high 8 and low 2.
- R11: During reset all occupancies are zero, all flags are clear and the header output is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hq_alloc | input | NQ | Per-queue allocated flag |
| hq_enq | input | NQ | Per-queue enqueue strobe |
| hq_deq | input | NQ | Per-queue dequeue strobe |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_high | input | CNT_W | New high threshold |
| cfg_low | input | CNT_W | New low threshold |
| hdr_in_valid | input | 1 | Departing header valid |
| hdr_in | input | HDR_W | Departing header |
| hdr_in_port | input | PW | Output port of the departing header |
| hdr_out_valid | output | 1 | Marked header valid |
| hdr_out | output | HDR_W | Header with congestion mark applied |
| hdr_out_port | output | PW | Output port of the marked header |
| port_cong | output | NP | Per-port congested flags |
| hq_level | output | NQ*CNT_W | Occupancy of each hot queue, queue 0 in the low bits |

## Verification
Two functions can act in the same cycle: a header departs on a flagged port, and that same flag is being cleared by the switch-wide release. The bench sets this up in three steps. It raises a port's flag and drains the queues until only one queue still holds the switch above the low threshold. It then deallocates that queue. In the cycle after, the flag is still set but is about to clear, and the bench presents a header for that port in exactly that cycle. It expects the header to leave marked, the flag to read clear in the same sample, and a second header presented one cycle later to leave unmarked.

// File: rtl/cm_pkg.sv
package cm_pkg;
    // Default geometry shared by the marker and its bench-facing defaults.
    localparam int DEF_PORTS     = 4;
    localparam int DEF_Q_PER_PORT = 2;
    localparam int DEF_CNT_W     = 5;
    localparam int DEF_HDR_W     = 16;
    localparam int DEF_MARK_POS  = 13;
    localparam int DEF_THR_HIGH  = 8;
    localparam int DEF_THR_LOW   = 2;

    // Returns the output port fed by a given hot queue.
    function automatic int q2port(input int q, input int q_per_port);
        return q / q_per_port;
    endfunction
endpackage

// File: rtl/cm_occ_counter.sv
// Occupancy counter for one hot queue.
// Assumes: strobes are single-cycle per packet; counter is held at zero
// while the queue is not allocated; saturates at both ends.
module cm_occ_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             enq,
    input  logic             deq,
    output logic [CNT_W-1:0] level
);
    localparam logic [CNT_W-1:0] LVL_MAX = '1;

    // Track occupancy from the strobes, forced to zero when deallocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (!alloc) begin
            level <= '0;
        end else if (enq && !deq && level != LVL_MAX) begin
            level <= level + 1'b1;
        end else if (deq && !enq && level != '0) begin
            level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/cm_port_state.sv
// Per-port congestion flags with switch-wide hysteretic release.
// Assumes: thr_lo < thr_hi (enforced by the threshold register), so a
// queue at or above thr_hi can never also be below thr_lo.
module cm_port_state #(
    parameter int NP    = 4,
    parameter int QPP   = 2,
    parameter int CNT_W = 5,
    localparam int NQ   = NP * QPP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NQ*CNT_W-1:0] levels,
    input  logic [CNT_W-1:0]    thr_hi,
    input  logic [CNT_W-1:0]    thr_lo,
    output logic [NP-1:0]       port_cong
);
    logic [NP-1:0] hit;
    logic [NQ-1:0] below;
    logic          release_all;

    // Per-port entry condition: any queue of the port at or above high.
    always_comb begin
        hit = '0;
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < QPP; k++) begin
                if (levels[(p*QPP+k)*CNT_W +: CNT_W] >= thr_hi) hit[p] = 1'b1;
            end
        end
    end

    // Per-queue release condition: occupancy strictly below low.
    generate
        for (genvar q = 0; q < NQ; q++) begin : g_below
            assign below[q] = levels[q*CNT_W +: CNT_W] < thr_lo;
        end
    endgenerate

    assign release_all = &below;

    // Set per port on entry, clear all ports on the switch-wide release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_cong <= '0;
        end else if (release_all) begin
            port_cong <= '0;
        end else begin
            port_cong <= port_cong | hit;
        end
    end
endmodule

// File: rtl/cm_hdr_mark.sv
// One-stage header pass-through that sets the forward congestion bit.
// Assumes: hdr_in_port is below NP; the mark uses the port flag as it
// stands in the cycle the header is presented.
module cm_hdr_mark #(
    parameter int NP       = 4,
    parameter int HDR_W    = 16,
    parameter int MARK_POS = 13,
    localparam int PW      = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    port_cong,
    input  logic             hdr_in_valid,
    input  logic [HDR_W-1:0] hdr_in,
    input  logic [PW-1:0]    hdr_in_port,
    output logic             hdr_out_valid,
    output logic [HDR_W-1:0] hdr_out,
    output logic [PW-1:0]    hdr_out_port
);
    localparam logic [HDR_W-1:0] MARK_MASK = HDR_W'(1) << MARK_POS;

    logic set_mark;

    // Decide whether this header picks up a mark from its port.
    assign set_mark = hdr_in_valid && port_cong[hdr_in_port];

    // Register the header, OR-ing in the mark so upstream marks persist.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_out_valid <= 1'b0;
            hdr_out       <= '0;
            hdr_out_port  <= '0;
        end else begin
            hdr_out_valid <= hdr_in_valid;
            hdr_out       <= set_mark ? (hdr_in | MARK_MASK) : hdr_in;
            hdr_out_port  <= hdr_in_port;
        end
    end
endmodule

// File: rtl/cm_marker.sv
// Top of the hysteretic congestion marker: per-queue occupancy counters,
// threshold register, per-port congestion state and header marking stage.
// Assumes: queue q feeds port q / QPP; allocation is decided outside.
module cm_marker #(
    parameter int NP       = cm_pkg::DEF_PORTS,
    parameter int QPP      = cm_pkg::DEF_Q_PER_PORT,
    parameter int CNT_W    = cm_pkg::DEF_CNT_W,
    parameter int HDR_W    = cm_pkg::DEF_HDR_W,
    parameter int MARK_POS = cm_pkg::DEF_MARK_POS,
    parameter int THR_HIGH = cm_pkg::DEF_THR_HIGH,
    parameter int THR_LOW  = cm_pkg::DEF_THR_LOW,
    localparam int NQ      = NP * QPP,
    localparam int PW      = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NQ-1:0]       hq_alloc,
    input  logic [NQ-1:0]       hq_enq,
    input  logic [NQ-1:0]       hq_deq,
    input  logic                cfg_wr,
    input  logic [CNT_W-1:0]    cfg_high,
    input  logic [CNT_W-1:0]    cfg_low,
    input  logic                hdr_in_valid,
    input  logic [HDR_W-1:0]    hdr_in,
    input  logic [PW-1:0]       hdr_in_port,
    output logic                hdr_out_valid,
    output logic [HDR_W-1:0]    hdr_out,
    output logic [PW-1:0]       hdr_out_port,
    output logic [NP-1:0]       port_cong,
    output logic [NQ*CNT_W-1:0] hq_level
);
    logic [CNT_W-1:0] thr_hi_q;
    logic [CNT_W-1:0] thr_lo_q;

    // Threshold register: accept a write only if low stays below high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_hi_q <= CNT_W'(THR_HIGH);
            thr_lo_q <= CNT_W'(THR_LOW);
        end else if (cfg_wr && (cfg_low < cfg_high)) begin
            thr_hi_q <= cfg_high;
            thr_lo_q <= cfg_low;
        end
    end

    // One occupancy counter per hot queue.
    generate
        for (genvar q = 0; q < NQ; q++) begin : g_occ
            cm_occ_counter #(.CNT_W(CNT_W)) i_occ (
                .clk   (clk),
                .rst_n (rst_n),
                .alloc (hq_alloc[q]),
                .enq   (hq_enq[q]),
                .deq   (hq_deq[q]),
                .level (hq_level[q*CNT_W +: CNT_W])
            );
        end
    endgenerate

    cm_port_state #(.NP(NP), .QPP(QPP), .CNT_W(CNT_W)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .levels    (hq_level),
        .thr_hi    (thr_hi_q),
        .thr_lo    (thr_lo_q),
        .port_cong (port_cong)
    );

    cm_hdr_mark #(.NP(NP), .HDR_W(HDR_W), .MARK_POS(MARK_POS)) i_mark (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_cong     (port_cong),
        .hdr_in_valid  (hdr_in_valid),
        .hdr_in        (hdr_in),
        .hdr_in_port   (hdr_in_port),
        .hdr_out_valid (hdr_out_valid),
        .hdr_out       (hdr_out),
        .hdr_out_port  (hdr_out_port)
    );
endmodule

// File: rtl/cm_marker_chk.sv
// Property checker for cm_marker, attached by bind below.
// Assumes: same parameters as the bound instance.
module cm_marker_chk #(
    parameter int NP       = 4,
    parameter int QPP      = 2,
    parameter int CNT_W    = 5,
    parameter int HDR_W    = 16,
    parameter int MARK_POS = 13,
    localparam int NQ      = NP * QPP,
    localparam int PW      = (NP > 1) ? $clog2(NP) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NQ-1:0]       hq_alloc,
    input logic [NQ-1:0]       hq_enq,
    input logic [NQ-1:0]       hq_deq,
    input logic [CNT_W-1:0]    thr_hi,
    input logic [CNT_W-1:0]    thr_lo,
    input logic                hdr_in_valid,
    input logic [HDR_W-1:0]    hdr_in,
    input logic [PW-1:0]       hdr_in_port,
    input logic                hdr_out_valid,
    input logic [HDR_W-1:0]    hdr_out,
    input logic [PW-1:0]       hdr_out_port,
    input logic [NP-1:0]       port_cong,
    input logic [NQ*CNT_W-1:0] hq_level
);
    localparam logic [CNT_W-1:0] LVL_MAX   = '1;
    localparam logic [HDR_W-1:0] KEEP_MASK = ~(HDR_W'(1) << MARK_POS);

    logic [NP-1:0] chk_hit;
    logic          chk_all_below;

    // Independent view of the entry and release conditions.
    always_comb begin
        chk_hit       = '0;
        chk_all_below = 1'b1;
        for (int q = 0; q < NQ; q++) begin
            if (hq_level[q*CNT_W +: CNT_W] >= thr_hi) chk_hit[q / QPP] = 1'b1;
            if (hq_level[q*CNT_W +: CNT_W] >= thr_lo) chk_all_below = 1'b0;
        end
    end

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_q
            assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
                hq_alloc[q] && hq_enq[q] && hq_deq[q]
                |=> hq_level[q*CNT_W +: CNT_W] == $past(hq_level[q*CNT_W +: CNT_W]));
            assert_dealloc_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !hq_alloc[q] |=> hq_level[q*CNT_W +: CNT_W] == '0);
            assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                hq_alloc[q] && hq_enq[q] && !hq_deq[q] && hq_level[q*CNT_W +: CNT_W] == LVL_MAX
                |=> hq_level[q*CNT_W +: CNT_W] == LVL_MAX);
        end
        for (genvar p = 0; p < NP; p++) begin : g_p
            assert_entry_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(port_cong[p]) |-> $past(chk_hit[p]));
            assert_hold_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
                port_cong[p] && !chk_all_below |=> port_cong[p]);
        end
    endgenerate

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_all_below |=> port_cong == '0);

    assert_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_in_valid |=> hdr_out_valid && hdr_out_port == $past(hdr_in_port)
            && (hdr_out[MARK_POS] == ($past(port_cong[hdr_in_port]) || $past(hdr_in[MARK_POS]))));

    assert_keep_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_in_valid && hdr_in[MARK_POS] |=> hdr_out[MARK_POS]);

    assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_in_valid |=> (hdr_out & KEEP_MASK) == ($past(hdr_in) & KEEP_MASK));

    assert_thr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        thr_lo < thr_hi);
endmodule

bind cm_marker cm_marker_chk #(
    .NP(NP), .QPP(QPP), .CNT_W(CNT_W), .HDR_W(HDR_W), .MARK_POS(MARK_POS)
) i_cm_marker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hq_alloc      (hq_alloc),
    .hq_enq        (hq_enq),
    .hq_deq        (hq_deq),
    .thr_hi        (thr_hi_q),
    .thr_lo        (thr_lo_q),
    .hdr_in_valid  (hdr_in_valid),
    .hdr_in        (hdr_in),
    .hdr_in_port   (hdr_in_port),
    .hdr_out_valid (hdr_out_valid),
    .hdr_out       (hdr_out),
    .hdr_out_port  (hdr_out_port),
    .port_cong     (port_cong),
    .hq_level      (hq_level)
);

// File: tb/test_cm_marker.sv
module test_cm_marker;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4, QPP = 2, NQ = 8, CNT_W = 5, HDR_W = 16, PW = 2;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NQ-1:0]       hq_alloc, hq_enq, hq_deq;
    logic                cfg_wr;
    logic [CNT_W-1:0]    cfg_high, cfg_low;
    logic                hdr_in_valid;
    logic [HDR_W-1:0]    hdr_in;
    logic [PW-1:0]       hdr_in_port;
    logic                hdr_out_valid;
    logic [HDR_W-1:0]    hdr_out;
    logic [PW-1:0]       hdr_out_port;
    logic [NP-1:0]       port_cong;
    logic [NQ*CNT_W-1:0] hq_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Header vectors: {port[17:16], header[15:0]}; port 1 is congested during the walk.
    localparam logic [17:0] VEC [8] = '{
        {2'd1, 16'h0000}, {2'd0, 16'h0000}, {2'd1, 16'hFFFF}, {2'd2, 16'h2000},
        {2'd3, 16'h1234}, {2'd1, 16'hDFFF}, {2'd0, 16'hA5A5}, {2'd1, 16'h5A5A}
    };

    cm_marker i_cm_marker (
        .clk(clk), .rst_n(rst_n), .hq_alloc(hq_alloc), .hq_enq(hq_enq), .hq_deq(hq_deq),
        .cfg_wr(cfg_wr), .cfg_high(cfg_high), .cfg_low(cfg_low),
        .hdr_in_valid(hdr_in_valid), .hdr_in(hdr_in), .hdr_in_port(hdr_in_port),
        .hdr_out_valid(hdr_out_valid), .hdr_out(hdr_out), .hdr_out_port(hdr_out_port),
        .port_cong(port_cong), .hq_level(hq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lvl(input int q);
        return 32'(hq_level[q*CNT_W +: CNT_W]);
    endfunction

    task automatic send_hdr(input logic [PW-1:0] p, input logic [HDR_W-1:0] h);
        hdr_in_valid = 1'b1; hdr_in_port = p; hdr_in = h;
        tick();
        hdr_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hq_alloc = '0; hq_enq = '0; hq_deq = '0;
        cfg_wr = 1'b0; cfg_high = '0; cfg_low = '0;
        hdr_in_valid = 1'b0; hdr_in = '0; hdr_in_port = '0;
        tick(3);
        // R11 reset state
        chk("R11 levels", 32'(hq_level), 32'h0);
        chk("R11 flags", 32'(port_cong), 32'h0);
        chk("R11 out valid", 32'(hdr_out_valid), 32'h0);
        rst_n = 1'b1;

        // R2 strobes ignored on an unallocated queue
        hq_enq[0] = 1'b1; tick(3); hq_enq[0] = 1'b0;
        chk("R2 unallocated level", lvl(0), 0);
        tick();
        chk("R2 no flag", 32'(port_cong), 0);

        hq_alloc = 8'h7F; tick();

        // R1 counting
        hq_enq[0] = 1'b1; tick(3); hq_enq[0] = 1'b0;
        chk("R1 three enqueues", lvl(0), 3);
        hq_enq[0] = 1'b1; hq_deq[0] = 1'b1; tick(); hq_enq[0] = 1'b0; hq_deq[0] = 1'b0;
        chk("R1 enq+deq", lvl(0), 3);
        hq_deq[0] = 1'b1; tick(); hq_deq[0] = 1'b0;
        chk("R1 dequeue", lvl(0), 2);

        // R4 entry on queue 2 (port 1) at default high 8
        hq_enq[2] = 1'b1; tick(7);
        chk("R4 level 7", lvl(2), 7);
        tick(); hq_enq[2] = 1'b0;
        chk("R4 flag lags level", 32'(port_cong), 0);
        tick();
        chk("R4 port1 flagged", 32'(port_cong), 32'b0010);

        // R7 R8 R9 table walk with port 1 flagged
        for (int i = 0; i < 8; i++) begin
            logic [HDR_W-1:0] h;
            logic [PW-1:0] p;
            p = VEC[i][17:16]; h = VEC[i][15:0];
            send_hdr(p, h);
            chk("R7 R8 R9 header", 32'(hdr_out), 32'(h | ((p == 2'd1) ? 16'h2000 : 16'h0000)));
            chk("R7 port/valid", 32'({hdr_out_valid, hdr_out_port}), 32'({1'b1, p}));
        end

        // R5 flag held while queue 0 (another port) stays at low
        hq_deq[2] = 1'b1; tick(7); hq_deq[2] = 1'b0;
        tick();
        chk("R5 level q2", lvl(2), 1);
        chk("R5 flag held", 32'(port_cong), 32'b0010);

        // R6 release via deallocation, same cycle as a departing header (R7)
        hq_alloc[0] = 1'b0; tick();
        chk("R6 flag before release", 32'(port_cong), 32'b0010);
        send_hdr(2'd1, 16'h0001);
        chk("R7 marked in releasing cycle", 32'(hdr_out), 32'h2001);
        chk("R6 released", 32'(port_cong), 0);
        send_hdr(2'd1, 16'h0001);
        chk("R7 unmarked after release", 32'(hdr_out), 32'h0001);
        hq_alloc[0] = 1'b1; hq_deq[2] = 1'b1; tick(); hq_deq[2] = 1'b0;

        // R10 rejected write keeps high 8
        cfg_wr = 1'b1; cfg_high = 5'd4; cfg_low = 5'd4; tick(); cfg_wr = 1'b0;
        hq_enq[1] = 1'b1; tick(4); hq_enq[1] = 1'b0;
        chk("R10 level q1", lvl(1), 4);
        tick();
        chk("R10 bad write ignored", 32'(port_cong), 0);
        cfg_wr = 1'b1; cfg_high = 5'd4; cfg_low = 5'd1; tick(); cfg_wr = 1'b0;
        tick();
        chk("R10 new high applied", 32'(port_cong), 32'b0001);
        hq_deq[1] = 1'b1; tick(3); hq_deq[1] = 1'b0;
        tick();
        chk("R5 held at low", 32'(port_cong), 32'b0001);
        hq_deq[1] = 1'b1; tick(); hq_deq[1] = 1'b0;
        tick();
        chk("R6 R10 released at new low", 32'(port_cong), 0);

        // R3 saturation at both ends
        hq_deq[3] = 1'b1; tick(2); hq_deq[3] = 1'b0;
        chk("R3 empty stays zero", lvl(3), 0);
        hq_enq[4] = 1'b1; tick(35); hq_enq[4] = 1'b0;
        chk("R3 full stays max", lvl(4), 31);
        hq_deq[4] = 1'b1; tick(); hq_deq[4] = 1'b0;
        chk("R1 dequeue from full", lvl(4), 30);
        chk("R4 port2 via queue 4", 32'(port_cong), 32'b0100);

        // R8 upstream mark kept on an unflagged port; R9 on plain header
        send_hdr(2'd0, 16'h2000);
        chk("R8 premark kept", 32'(hdr_out), 32'h2000);
        send_hdr(2'd0, 16'h0040);
        chk("R9 unflagged port unchanged", 32'(hdr_out), 32'h0040);

        // R2 queue 7 never allocated
        hq_enq[7] = 1'b1; tick(2); hq_enq[7] = 1'b0;
        chk("R2 queue 7 ignored", lvl(7), 0);

        finish_run();
    end
endmodule